// File: doc/BRIEF.md
# Vector Memory Access Legality Checker

This block sits in the decode path of a vector unit. It looks at one vector load or store together with the vector type that is currently set. It works out the element width and the register-group multiplier of the data group and, for indexed accesses, of the index group. It then decides whether the access may execute or must raise an illegal-instruction exception. Address generation and the memory transfer itself belong to other blocks.

The decision logic is combinational. Its result is held in one output register, so a result appears on the clock edge after its inputs were presented. Multipliers are reported as signed base-2 logarithms in 4-bit two's complement (for example -1 means one half and 2 means four). Element widths are reported as the base-2 logarithm of the byte count.

Top module: `vmem_legal_chk`

## Requirements
- R1: The memory-width code decodes as 0 = 1 byte, 5 = 2 bytes, 6 = 4 bytes and 7 = 8 bytes, and is reported on `res_eew` as 0, 1, 2 and 3. For unit, strided and mask accesses any other code is illegal and reports width 0. For indexed accesses an unlisted code is treated as a 1-byte index and is not illegal on its own.
- R2: For unit and strided accesses, `res_emul` = width log2 − selected-width log2 + multiplier log2. The selected-width code (`cfg_sew`) gives log2 bytes 0 to 3. The multiplier code (`cfg_lmul`) 0 to 3 means log2 0 to 3, and codes 5, 6 and 7 mean −3, −2 and −1.
- R3: Mode 2 (mask) reports a 1-byte element and a multiplier log2 of 0, whatever the type setting is.
- R4: A data or index multiplier log2 outside −3..3 is illegal.
- R5: When the data multiplier log2 e is above 0, a destination register that is not a multiple of 2^e is illegal.
- R6: With segment count nf = `acc_segs` + 1 and a group span of 2^max(e,0), the access is illegal when nf × span exceeds 8 or `acc_vd` + nf × span exceeds 32.
- R7: For indexed accesses (mode 3), `res_eew` equals the selected width and `res_emul` equals the configured multiplier. `res_idx_emul` = index width log2 − selected-width log2 + multiplier log2. Misalignment of either group is illegal. For other modes `res_idx_emul` is 0.
- R8: For indexed loads, every segment destination group (start `acc_vd` + k × span) that overlaps the index group is illegal. With a single segment there are two exceptions: an index wider than the data element whose group starts on the same register, and index and data of equal width. Indexed stores skip this rule.
- R9: A masked load (`acc_masked` = 1, `acc_is_load` = 1) with `acc_vd` = 0 is illegal. Masked stores and unmasked loads with `acc_vd` = 0 are not made illegal by this rule.
- R10: A reserved multiplier code (4) or a selected-width code of 4 or higher is illegal.
- R11: All results appear one clock after their inputs. While `rst_n` is low every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_mode | input | 2 | 0 unit, 1 strided, 2 mask, 3 indexed |
| acc_is_load | input | 1 | 1 for a load, 0 for a store |
| acc_masked | input | 1 | 1 when the access is masked |
| acc_width | input | 3 | Memory-width code |
| acc_segs | input | 3 | Segment count minus one |
| acc_vd | input | 5 | Data (destination or source) register number |
| acc_vidx | input | 5 | Index register number |
| cfg_sew | input | 3 | Selected-width code from the type setting |
| cfg_lmul | input | 3 | Multiplier code from the type setting |
| res_eew | output | 2 | Data element width, log2 bytes |
| res_emul | output | 4 | Data multiplier, signed log2 |
| res_idx_emul | output | 4 | Index multiplier, signed log2 |
| res_illegal | output | 1 | 1 when the access is illegal |

## Verification
The rules are exercised with width/type pairs whose multiplier grows, shrinks and runs past both range ends. This separates a sign or offset error in the multiplier arithmetic from a wrong range limit. Register numbers are placed exactly on and one step past the alignment and register-file boundaries, so an off-by-one in the segment sums shows up. Indexed loads use wider, narrower and equal index widths with shared, partly overlapping and disjoint groups, with one and two segments, to test each overlap exception on its own. Paired load/store and masked/unmasked accesses to register 0 show that each rule applies only where it should.

// File: rtl/vmchk_pkg.sv
package vmchk_pkg;

    localparam int L2_W = 4;

    typedef enum logic [1:0] {
        ACC_UNIT   = 2'd0,
        ACC_STRIDE = 2'd1,
        ACC_MASK   = 2'd2,
        ACC_INDEX  = 2'd3
    } acc_mode_e;

    typedef struct packed {
        logic [1:0]      eew;
        logic [L2_W-1:0] emul;
        logic [L2_W-1:0] idx_emul;
        logic            illegal;
    } chk_res_t;

endpackage

// File: rtl/vmchk_field_dec.sv
module vmchk_field_dec import vmchk_pkg::*; (
    input  logic              [2:0]      width_code,
    input  logic              [2:0]      sew_code,
    input  logic              [2:0]      lmul_code,
    output logic              [1:0]      width_l2,
    output logic                         width_ok,
    output logic              [1:0]      sew_l2,
    output logic signed       [L2_W-1:0] lmul_l2,
    output logic                         type_ok
);
    always_comb begin
        width_ok = 1'b1;
        unique case (width_code)
            3'd0:    width_l2 = 2'd0;
            3'd5:    width_l2 = 2'd1;
            3'd6:    width_l2 = 2'd2;
            3'd7:    width_l2 = 2'd3;
            default: begin
                width_l2 = 2'd0;
                width_ok = 1'b0;
            end
        endcase

        sew_l2  = sew_code[2] ? 2'd0 : sew_code[1:0];
        lmul_l2 = (lmul_code == 3'd4) ? '0 : {lmul_code[2], lmul_code};
        type_ok = !sew_code[2] && (lmul_code != 3'd4);
    end
endmodule

// File: rtl/vmchk_group_chk.sv
module vmchk_group_chk import vmchk_pkg::*; #(
    parameter int REG_W      = 5,
    parameter int MAX_GRP_L2 = 3
) (
    input  logic        [REG_W-1:0]      start,
    input  logic signed [L2_W-1:0]       emul,
    output logic                         range_bad,
    output logic                         align_bad,
    output logic        [MAX_GRP_L2:0]   span
);
    localparam int SPAN_W = MAX_GRP_L2 + 1;
    localparam logic signed [L2_W-1:0] L2_MAX = L2_W'(MAX_GRP_L2);
    localparam logic signed [L2_W-1:0] L2_MIN = -L2_MAX;

    logic [L2_W-1:0] shift_amt;

    always_comb begin
        range_bad = (emul > L2_MAX) || (emul < L2_MIN);
        if (emul <= 0)
            shift_amt = '0;
        else if (emul > L2_MAX)
            shift_amt = L2_MAX;
        else
            shift_amt = emul;
        span      = SPAN_W'(1) << shift_amt;
        align_bad = (emul > 0) && ((start & REG_W'(span - 1'b1)) != '0);
    end
endmodule

// File: rtl/vmchk_overlap.sv
module vmchk_overlap #(
    parameter int NUM_SEGS = 8,
    parameter int REG_W    = 5,
    parameter int SPAN_W   = 4
) (
    input  logic                         en,
    input  logic [$clog2(NUM_SEGS):0]    nf,
    input  logic [REG_W-1:0]             vd,
    input  logic [SPAN_W-1:0]            data_span,
    input  logic [REG_W-1:0]             vidx,
    input  logic [SPAN_W-1:0]            idx_span,
    input  logic                         idx_wider,
    input  logic                         idx_equal,
    output logic                         bad
);
    localparam int OVL_W = REG_W + SPAN_W + 1;
    localparam int NF_W  = $clog2(NUM_SEGS) + 1;

    logic                  single;
    logic [OVL_W-1:0]      i_lo;
    logic [OVL_W-1:0]      i_hi;
    logic [NUM_SEGS-1:0]   seg_bad;

    assign single = (nf == NF_W'(1));
    assign i_lo   = OVL_W'(vidx);
    assign i_hi   = OVL_W'(vidx) + OVL_W'(idx_span);

    for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
        logic [OVL_W-1:0] lo;
        logic [OVL_W-1:0] hi;
        logic             hit;
        logic             exempt;
        assign lo      = OVL_W'(vd) + OVL_W'(s) * OVL_W'(data_span);
        assign hi      = lo + OVL_W'(data_span);
        assign hit     = (lo < i_hi) && (i_lo < hi);
        assign exempt  = single && (idx_wider ? (lo == i_lo) : idx_equal);
        assign seg_bad[s] = (OVL_W'(s) < OVL_W'(nf)) && hit && !exempt;
    end

    assign bad = en && (|seg_bad);
endmodule

// File: rtl/vmem_legal_chk.sv
module vmem_legal_chk import vmchk_pkg::*; #(
    parameter int NUM_VREGS = 32,
    parameter int MAX_GRP   = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     acc_mode,
    input  logic                           acc_is_load,
    input  logic                           acc_masked,
    input  logic [2:0]                     acc_width,
    input  logic [$clog2(MAX_GRP)-1:0]     acc_segs,
    input  logic [$clog2(NUM_VREGS)-1:0]   acc_vd,
    input  logic [$clog2(NUM_VREGS)-1:0]   acc_vidx,
    input  logic [2:0]                     cfg_sew,
    input  logic [2:0]                     cfg_lmul,
    output logic [1:0]                     res_eew,
    output logic [3:0]                     res_emul,
    output logic [3:0]                     res_idx_emul,
    output logic                           res_illegal
);
    localparam int REG_W      = $clog2(NUM_VREGS);
    localparam int MAX_GRP_L2 = $clog2(MAX_GRP);
    localparam int SEG_W      = MAX_GRP_L2;
    localparam int SPAN_W     = MAX_GRP_L2 + 1;
    localparam int PROD_W     = REG_W + SPAN_W + 1;

    logic                     is_idx;
    logic                     is_mask;
    logic [1:0]               width_l2;
    logic                     width_ok;
    logic [1:0]               sew_l2;
    logic signed [L2_W-1:0]   lmul_l2;
    logic                     type_ok;
    logic signed [L2_W-1:0]   ratio_emul;
    logic signed [L2_W-1:0]   data_emul;
    logic                     d_range_bad, d_align_bad;
    logic                     i_range_bad, i_align_bad;
    logic [SPAN_W-1:0]        d_span, i_span;
    logic [SEG_W:0]           nf;
    logic [PROD_W-1:0]        seg_prod;
    logic [PROD_W-1:0]        seg_end;
    logic                     ovl_bad;

    chk_res_t res_d, res_q;

    assign is_idx  = (acc_mode == ACC_INDEX);
    assign is_mask = (acc_mode == ACC_MASK);

    vmchk_field_dec i_dec (
        .width_code (acc_width),
        .sew_code   (cfg_sew),
        .lmul_code  (cfg_lmul),
        .width_l2   (width_l2),
        .width_ok   (width_ok),
        .sew_l2     (sew_l2),
        .lmul_l2    (lmul_l2),
        .type_ok    (type_ok)
    );

    assign ratio_emul = $signed({2'b00, width_l2}) - $signed({2'b00, sew_l2}) + lmul_l2;
    assign data_emul  = is_mask ? '0 : (is_idx ? lmul_l2 : ratio_emul);

    vmchk_group_chk #(.REG_W(REG_W), .MAX_GRP_L2(MAX_GRP_L2)) i_data_grp (
        .start     (acc_vd),
        .emul      (data_emul),
        .range_bad (d_range_bad),
        .align_bad (d_align_bad),
        .span      (d_span)
    );

    vmchk_group_chk #(.REG_W(REG_W), .MAX_GRP_L2(MAX_GRP_L2)) i_idx_grp (
        .start     (acc_vidx),
        .emul      (ratio_emul),
        .range_bad (i_range_bad),
        .align_bad (i_align_bad),
        .span      (i_span)
    );

    assign nf       = {1'b0, acc_segs} + 1'b1;
    assign seg_prod = PROD_W'(nf) * PROD_W'(d_span);
    assign seg_end  = PROD_W'(acc_vd) + seg_prod;

    vmchk_overlap #(.NUM_SEGS(MAX_GRP), .REG_W(REG_W), .SPAN_W(SPAN_W)) i_ovl (
        .en        (is_idx && acc_is_load),
        .nf        (nf),
        .vd        (acc_vd),
        .data_span (d_span),
        .vidx      (acc_vidx),
        .idx_span  (i_span),
        .idx_wider (width_l2 > sew_l2),
        .idx_equal (width_l2 == sew_l2),
        .bad       (ovl_bad)
    );

    always_comb begin
        res_d          = '0;
        res_d.eew      = is_mask ? 2'd0 : (is_idx ? sew_l2 : width_l2);
        res_d.emul     = data_emul;
        res_d.idx_emul = is_idx ? ratio_emul : '0;
        res_d.illegal  = !type_ok
                      || (!is_idx && !width_ok)
                      || d_range_bad || d_align_bad
                      || (seg_prod > PROD_W'(MAX_GRP))
                      || (seg_end > PROD_W'(NUM_VREGS))
                      || (is_idx && (i_range_bad || i_align_bad))
                      || ovl_bad
                      || (acc_is_load && acc_masked && (acc_vd == '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign res_eew      = res_q.eew;
    assign res_emul     = res_q.emul;
    assign res_idx_emul = res_q.idx_emul;
    assign res_illegal  = res_q.illegal;
endmodule

// File: rtl/vmem_legal_chk_sva.sv
module vmem_legal_chk_sva #(
    parameter int NUM_VREGS = 32,
    parameter int MAX_GRP   = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [1:0]                     acc_mode,
    input logic                           acc_is_load,
    input logic                           acc_masked,
    input logic [2:0]                     acc_width,
    input logic [$clog2(MAX_GRP)-1:0]     acc_segs,
    input logic [$clog2(NUM_VREGS)-1:0]   acc_vd,
    input logic [2:0]                     cfg_sew,
    input logic [2:0]                     cfg_lmul,
    input logic [1:0]                     res_eew,
    input logic [3:0]                     res_emul,
    input logic                           res_illegal
);
    localparam int REG_W = $clog2(NUM_VREGS);

    // R1
    assert_bad_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode != 2'd3 && acc_width != 3'd0 && acc_width < 3'd5) |=> res_illegal);

    // R3
    assert_mask_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'd2) |=> (res_eew == 2'd0 && res_emul == 4'd0));

    // R6
    assert_seg_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_segs == '1 && acc_vd > REG_W'(NUM_VREGS - MAX_GRP)) |=> res_illegal);

    // R7
    assert_idx_data_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'd3 && !cfg_sew[2]) |=> (res_eew == $past(cfg_sew[1:0])));

    // R9
    assert_masked_v0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_is_load && acc_masked && acc_vd == '0) |=> res_illegal);

    // R10
    assert_reserved_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_lmul == 3'd4 || cfg_sew[2]) |=> res_illegal);
endmodule

bind vmem_legal_chk vmem_legal_chk_sva #(.NUM_VREGS(NUM_VREGS), .MAX_GRP(MAX_GRP)) i_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_mode    (acc_mode),
    .acc_is_load (acc_is_load),
    .acc_masked  (acc_masked),
    .acc_width   (acc_width),
    .acc_segs    (acc_segs),
    .acc_vd      (acc_vd),
    .cfg_sew     (cfg_sew),
    .cfg_lmul    (cfg_lmul),
    .res_eew     (res_eew),
    .res_emul    (res_emul),
    .res_illegal (res_illegal)
);

// File: tb/test_vmem_legal_chk.sv
module test_vmem_legal_chk;

    typedef struct packed {
        logic [1:0] mode;
        logic       load;
        logic       masked;
        logic [2:0] width;
        logic [2:0] segs;
        logic [4:0] vd;
        logic [4:0] vidx;
        logic [2:0] sew;
        logic [2:0] lmul;
        logic [1:0] x_eew;
        logic [3:0] x_emul;
        logic [3:0] x_iemul;
        logic       x_ill;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 32;
    // fields: mode load masked width segs vd vidx sew lmul | eew emul iemul ill | req
    localparam vec_t VECS [NVEC] = '{
        '{2'd0,1'b1,1'b0,3'd0,3'd0,5'd8, 5'd0, 3'd0,3'd0, 2'd0,4'h0,4'h0,1'b0, 4'd1},  // R1 byte
        '{2'd0,1'b1,1'b0,3'd5,3'd0,5'd4, 5'd0, 3'd0,3'd1, 2'd1,4'h2,4'h0,1'b0, 4'd2},  // R2 grows
        '{2'd0,1'b1,1'b0,3'd5,3'd0,5'd2, 5'd0, 3'd0,3'd1, 2'd1,4'h2,4'h0,1'b1, 4'd5},  // R5 misaligned
        '{2'd1,1'b1,1'b0,3'd7,3'd0,5'd0, 5'd0, 3'd0,3'd1, 2'd3,4'h4,4'h0,1'b1, 4'd4},  // R4 too big
        '{2'd0,1'b1,1'b0,3'd0,3'd0,5'd0, 5'd0, 3'd3,3'd5, 2'd0,4'hA,4'h0,1'b1, 4'd4},  // R4 too small
        '{2'd0,1'b1,1'b0,3'd6,3'd7,5'd3, 5'd0, 3'd2,3'd7, 2'd2,4'hF,4'h0,1'b0, 4'd6},  // R6 eight segs
        '{2'd0,1'b1,1'b0,3'd5,3'd3,5'd24,5'd0, 3'd1,3'd1, 2'd1,4'h1,4'h0,1'b0, 4'd6},  // R6 ends at 32
        '{2'd0,1'b1,1'b0,3'd5,3'd3,5'd26,5'd0, 3'd1,3'd1, 2'd1,4'h1,4'h0,1'b1, 4'd6},  // R6 past 32
        '{2'd0,1'b1,1'b0,3'd5,3'd4,5'd0, 5'd0, 3'd1,3'd1, 2'd1,4'h1,4'h0,1'b1, 4'd6},  // R6 product 10
        '{2'd0,1'b1,1'b0,3'd3,3'd0,5'd8, 5'd0, 3'd0,3'd0, 2'd0,4'h0,4'h0,1'b1, 4'd1},  // R1 bad code
        '{2'd2,1'b1,1'b0,3'd0,3'd0,5'd5, 5'd0, 3'd3,3'd6, 2'd0,4'h0,4'h0,1'b0, 4'd3},  // R3 mask
        '{2'd0,1'b1,1'b1,3'd0,3'd0,5'd0, 5'd0, 3'd0,3'd0, 2'd0,4'h0,4'h0,1'b1, 4'd9},  // R9 masked load v0
        '{2'd0,1'b0,1'b1,3'd0,3'd0,5'd0, 5'd0, 3'd0,3'd0, 2'd0,4'h0,4'h0,1'b0, 4'd9},  // R9 masked store v0
        '{2'd0,1'b1,1'b1,3'd0,3'd0,5'd1, 5'd0, 3'd0,3'd0, 2'd0,4'h0,4'h0,1'b0, 4'd9},  // R9 masked load v1
        '{2'd0,1'b1,1'b0,3'd0,3'd0,5'd8, 5'd0, 3'd0,3'd4, 2'd0,4'h0,4'h0,1'b1, 4'd10}, // R10 lmul code 4
        '{2'd0,1'b1,1'b0,3'd0,3'd0,5'd8, 5'd0, 3'd4,3'd0, 2'd0,4'h0,4'h0,1'b1, 4'd10}, // R10 sew code 4
        '{2'd3,1'b1,1'b0,3'd6,3'd0,5'd8, 5'd12,3'd0,3'd0, 2'd0,4'h0,4'h2,1'b0, 4'd7},  // R7 legal
        '{2'd3,1'b1,1'b0,3'd6,3'd0,5'd8, 5'd10,3'd0,3'd0, 2'd0,4'h0,4'h2,1'b1, 4'd7},  // R7 index misaligned
        '{2'd3,1'b1,1'b0,3'd0,3'd0,5'd3, 5'd10,3'd3,3'd1, 2'd3,4'h1,4'hE,1'b1, 4'd7},  // R7 data misaligned
        '{2'd3,1'b1,1'b0,3'd7,3'd0,5'd2, 5'd16,3'd0,3'd1, 2'd0,4'h1,4'h4,1'b1, 4'd4},  // R4 index range
        '{2'd3,1'b1,1'b0,3'd6,3'd0,5'd12,5'd12,3'd0,3'd0, 2'd0,4'h0,4'h2,1'b0, 4'd8},  // R8 wider same start
        '{2'd3,1'b1,1'b0,3'd6,3'd0,5'd13,5'd12,3'd0,3'd0, 2'd0,4'h0,4'h2,1'b1, 4'd8},  // R8 wider partial
        '{2'd3,1'b0,1'b0,3'd6,3'd0,5'd13,5'd12,3'd0,3'd0, 2'd0,4'h0,4'h2,1'b0, 4'd8},  // R8 store skips
        '{2'd3,1'b1,1'b0,3'd0,3'd0,5'd4, 5'd5, 3'd2,3'd1, 2'd2,4'h1,4'hF,1'b1, 4'd8},  // R8 narrower
        '{2'd3,1'b1,1'b0,3'd5,3'd0,5'd7, 5'd7, 3'd1,3'd0, 2'd1,4'h0,4'h0,1'b0, 4'd8},  // R8 equal, 1 seg
        '{2'd3,1'b1,1'b0,3'd5,3'd1,5'd7, 5'd7, 3'd1,3'd0, 2'd1,4'h0,4'h0,1'b1, 4'd8},  // R8 equal, 2 segs
        '{2'd3,1'b1,1'b0,3'd5,3'd1,5'd7, 5'd9, 3'd1,3'd0, 2'd1,4'h0,4'h0,1'b0, 4'd8},  // R8 disjoint
        '{2'd3,1'b1,1'b0,3'd5,3'd1,5'd7, 5'd8, 3'd1,3'd0, 2'd1,4'h0,4'h0,1'b1, 4'd8},  // R8 second seg hits
        '{2'd3,1'b1,1'b0,3'd6,3'd1,5'd12,5'd12,3'd0,3'd0, 2'd0,4'h0,4'h2,1'b1, 4'd8},  // R8 wider, 2 segs
        '{2'd3,1'b1,1'b0,3'd3,3'd0,5'd4, 5'd20,3'd0,3'd0, 2'd0,4'h0,4'h0,1'b0, 4'd1},  // R1 indexed odd code
        '{2'd3,1'b1,1'b0,3'd0,3'd1,5'd28,5'd0, 3'd0,3'd2, 2'd0,4'h2,4'h2,1'b1, 4'd6},  // R6 indexed overrun
        '{2'd0,1'b1,1'b0,3'd0,3'd0,5'd9, 5'd0, 3'd2,3'd0, 2'd0,4'hE,4'h0,1'b0, 4'd2}   // R2 shrinks
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_mode = '0;
    logic       acc_is_load = 1'b0;
    logic       acc_masked = 1'b0;
    logic [2:0] acc_width = '0;
    logic [2:0] acc_segs = '0;
    logic [4:0] acc_vd = '0;
    logic [4:0] acc_vidx = '0;
    logic [2:0] cfg_sew = '0;
    logic [2:0] cfg_lmul = '0;
    logic [1:0] res_eew;
    logic [3:0] res_emul;
    logic [3:0] res_idx_emul;
    logic       res_illegal;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vmem_legal_chk i_vmem_legal_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_mode     (acc_mode),
        .acc_is_load  (acc_is_load),
        .acc_masked   (acc_masked),
        .acc_width    (acc_width),
        .acc_segs     (acc_segs),
        .acc_vd       (acc_vd),
        .acc_vidx     (acc_vidx),
        .cfg_sew      (cfg_sew),
        .cfg_lmul     (cfg_lmul),
        .res_eew      (res_eew),
        .res_emul     (res_emul),
        .res_idx_emul (res_idx_emul),
        .res_illegal  (res_illegal)
    );

    task automatic drive(input vec_t v);
        acc_mode    = v.mode;
        acc_is_load = v.load;
        acc_masked  = v.masked;
        acc_width   = v.width;
        acc_segs    = v.segs;
        acc_vd      = v.vd;
        acc_vidx    = v.vidx;
        cfg_sew     = v.sew;
        cfg_lmul    = v.lmul;
    endtask

    task automatic expect_all(input string tag, input logic [1:0] e_eew, input logic [3:0] e_emul,
                              input logic [3:0] e_iemul, input logic e_ill);
        checks++;
        if (res_eew !== e_eew || res_emul !== e_emul || res_idx_emul !== e_iemul || res_illegal !== e_ill) begin
            failures++;
            $display("FAIL %s: got eew=%0d emul=%h iemul=%h ill=%b, expected eew=%0d emul=%h iemul=%h ill=%b",
                     tag, res_eew, res_emul, res_idx_emul, res_illegal, e_eew, e_emul, e_iemul, e_ill);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog R11: run did not complete, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11: outputs held at zero while reset is asserted, even with an illegal input
        drive(VECS[2]);
        repeat (3) @(negedge clk);
        expect_all("R11 reset state", 2'd0, 4'h0, 4'h0, 1'b0);
        rst_n = 1'b1;

        // table walk: result sampled at the falling edge after one rising edge
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            expect_all($sformatf("R%0d vector %0d", VECS[i].req, i),
                       VECS[i].x_eew, VECS[i].x_emul, VECS[i].x_iemul, VECS[i].x_ill);
        end

        // R11: one-cycle latency, output holds until the next rising edge
        @(negedge clk);
        drive(VECS[2]);
        @(negedge clk);
        drive(VECS[0]);
        #2;
        expect_all("R11 holds before edge", 2'd1, 4'h2, 4'h0, 1'b1);
        @(negedge clk);
        expect_all("R11 updates after edge", 2'd0, 4'h0, 4'h0, 1'b0);

        // R11: reset in mid-run clears a nonzero result
        drive(VECS[19]);
        @(negedge clk);
        expect_all("R11 before reset", 2'd0, 4'h1, 4'h4, 1'b1);
        rst_n = 1'b0;
        #1;
        expect_all("R11 async clear", 2'd0, 4'h0, 4'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_all("R11 after release", 2'd0, 4'h1, 4'h4, 1'b1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule